// File: doc/BRIEF.md
# Concurrent Test-Vector Prediction Checker

This block watches a small finite state machine while it runs and reports permanent faults without touching the machine. The machine is a 2-bit counter that counts up or down, depending on one direction input. Beside it sits a predictor that knows the correct next state only for a short list of direction/state pairs, called the test set. When the live pair is in the list, the predictor registers its expected next state together with a valid flag. On the following cycle it compares that expectation against the counter's state register. Every other pair leaves the flag low, and the comparison is then discarded.

The predictor always works from the counter's real state register, so a missed or masked cycle never leaves the checker out of step. Because the comparison is delayed by one register stage, faults in the state register are caught as well as faults in the next-state logic. For the testbench, each next-state bit has a stuck-at override that injects a fault. Once raised, the alarm stays high until reset.

Top module: `conc_pred_checker`

## Requirements
- R1: With no fault injected, `up_dn`=1 advances `state_o` by one modulo 4 on each clock and `up_dn`=0 steps it back by one modulo 4. The checker never alters this sequence.
- R2: The default test set holds four pairs, written as direction, current state and expected next state: up,00,01; up,01,10; down,11,10; down,00,11. The up direction is `up_dn`=1. On these pairs the expected next state is registered with a set valid flag.
- R3: For any pair outside the test set, the prediction is 00 and the valid flag is cleared. A wrong next state produced on such a cycle never raises `alarm_o`.
- R4: If the registered valid flag is set and `state_o` differs from the registered prediction, `alarm_o` goes high at the next clock edge. That is the second edge after the faulty transition.
- R5: Once `alarm_o` is high, it stays high until `rst_n` is asserted.
- R6: While `rst_n` is low, `state_o` is 00 and `alarm_o` is 0. The valid flag is also cleared, so no comparison happens on the first cycle after release.
- R7: `stuck_en[i]`=1 forces bit i of the counter's next state to `stuck_val[i]`. An injected value that equals the correct value raises no alarm.
- R8: Across the default test set, each state bit is expected as both 0 and 1. A stuck-at-0 or stuck-at-1 on either next-state bit is therefore flagged once a matching pair occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_dn | input | 1 | Count direction: 1 counts up, 0 counts down |
| stuck_en | input | 2 | Per-bit enable for the next-state fault override (testbench use only) |
| stuck_val | input | 2 | Value forced onto each overridden next-state bit |
| state_o | output | 2 | Counter state register |
| alarm_o | output | 1 | Sticky fault indication |

## Verification
The count-step property assumes that no override is active in the cycle it checks. The stimulus therefore enables an override for exactly one transition at a time and clears it on the next. The alarm-cause property assumes that the alarm can only rise because of a valid mismatch. The bench follows every fault with clean cycles and then a reset. Stimulus covers both directions through every state, a fault masked by a non-test pair, a harmless override, and a stuck-at of each polarity on each bit.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int SW = 2;
  localparam int EW = 1 + 2 * SW;

  typedef struct packed {
    logic          dir;
    logic [SW-1:0] cur;
    logic [SW-1:0] nxt;
  } tv_entry_t;
endpackage

// File: rtl/cpc_updown_fsm.sv
module cpc_updown_fsm
  import cpc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_dn,
  input  logic [SW-1:0] stuck_en,
  input  logic [SW-1:0] stuck_val,
  output logic [SW-1:0] state
);
  logic [SW-1:0] ns_raw;
  logic [SW-1:0] ns;

  always_comb begin
    if (up_dn) ns_raw = state + SW'(1);
    else       ns_raw = state - SW'(1);
  end

  // fault hook: per-bit override of the next-state value
  for (genvar b = 0; b < SW; b++) begin : g_hook
    assign ns[b] = stuck_en[b] ? stuck_val[b] : ns_raw[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= ns;
  end
endmodule

// File: rtl/cpc_predictor.sv
module cpc_predictor
  import cpc_pkg::*;
#(
  parameter int                     MAX_VEC  = 8,
  parameter int                     NUM_VEC  = 4,
  parameter logic [MAX_VEC*EW-1:0]  TV_TABLE = '0
) (
  input  logic          up_dn,
  input  logic [SW-1:0] cur_state,
  output logic          hit,
  output logic [SW-1:0] pred
);
  logic [MAX_VEC-1:0] match;
  logic [SW-1:0]      contrib [MAX_VEC];

  for (genvar g = 0; g < MAX_VEC; g++) begin : g_ent
    tv_entry_t ent;
    assign ent = TV_TABLE[g*EW +: EW];
    if (g < NUM_VEC) begin : g_live
      assign match[g] = (ent.dir == up_dn) && (ent.cur == cur_state);
    end else begin : g_off
      assign match[g] = 1'b0;
    end
    assign contrib[g] = match[g] ? ent.nxt : '0;
  end

  assign hit = |match;

  // off-table cycles leave every contribution at zero
  always_comb begin
    pred = '0;
    for (int k = 0; k < MAX_VEC; k++) pred = pred | contrib[k];
  end
endmodule

// File: rtl/cpc_compare.sv
module cpc_compare
  import cpc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [SW-1:0] pred,
  input  logic [SW-1:0] state,
  output logic          valid_q,
  output logic [SW-1:0] pred_q,
  output logic          alarm
);
  logic mismatch;
  logic alarm_en;

  always_comb begin
    mismatch = valid_q && (state != pred_q);
    alarm_en = mismatch && !alarm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pred_q  <= '0;
    end else begin
      valid_q <= hit;
      pred_q  <= pred;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alarm <= 1'b0;
    else if (alarm_en) alarm <= 1'b1;
  end
endmodule

// File: rtl/conc_pred_checker.sv
module conc_pred_checker
  import cpc_pkg::*;
#(
  parameter int                    MAX_VEC  = 8,
  parameter int                    NUM_VEC  = 4,
  parameter logic [MAX_VEC*EW-1:0] TV_TABLE = {20'b0,
                                               5'b0_00_11, 5'b0_11_10,
                                               5'b1_01_10, 5'b1_00_01}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_dn,
  input  logic [1:0] stuck_en,
  input  logic [1:0] stuck_val,
  output logic [1:0] state_o,
  output logic       alarm_o
);
  logic [SW-1:0] fsm_state;
  logic          tv_hit;
  logic [SW-1:0] tv_pred;
  logic          cmp_valid_q;
  logic [SW-1:0] cmp_pred_q;
  logic          cmp_alarm;

  cpc_updown_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_dn     (up_dn),
    .stuck_en  (stuck_en),
    .stuck_val (stuck_val),
    .state     (fsm_state)
  );

  cpc_predictor #(
    .MAX_VEC  (MAX_VEC),
    .NUM_VEC  (NUM_VEC),
    .TV_TABLE (TV_TABLE)
  ) u_pred (
    .up_dn     (up_dn),
    .cur_state (fsm_state),
    .hit       (tv_hit),
    .pred      (tv_pred)
  );

  cpc_compare u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (tv_hit),
    .pred    (tv_pred),
    .state   (fsm_state),
    .valid_q (cmp_valid_q),
    .pred_q  (cmp_pred_q),
    .alarm   (cmp_alarm)
  );

  assign state_o = fsm_state;
  assign alarm_o = cmp_alarm;
endmodule

// File: rtl/conc_pred_checker_sva.sv
module conc_pred_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       up_dn,
  input logic [1:0] stuck_en,
  input logic [1:0] state,
  input logic       hit,
  input logic [1:0] pred,
  input logic       valid_q,
  input logic [1:0] pred_q,
  input logic       alarm
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck_en == 2'b00) |=>
      (state == ($past(up_dn) ? 2'($past(state) + 2'd1) : 2'($past(state) - 2'd1))));

  a_r3_pred_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (pred == 2'b00));

  a_r3_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !valid_q);

  a_r4_alarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> ($past(valid_q) && ($past(state) != $past(pred_q))));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm);
endmodule

bind conc_pred_checker conc_pred_checker_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_dn    (up_dn),
  .stuck_en (stuck_en),
  .state    (state_o),
  .hit      (tv_hit),
  .pred     (tv_pred),
  .valid_q  (cmp_valid_q),
  .pred_q   (cmp_pred_q),
  .alarm    (alarm_o)
);

// File: tb/conc_pred_checker_bench.sv
module conc_pred_checker_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       up_dn;
  logic [1:0] stuck_en;
  logic [1:0] stuck_val;
  logic [1:0] state_o;
  logic       alarm_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    logic [1:0] st;
    logic       al;
    string      tag;
  } exp_t;
  exp_t q[$];

  // bench-side reference state
  logic [1:0] m_st, m_pp;
  logic       m_pv, m_al;

  always #5 clk = ~clk;

  conc_pred_checker u_conc_pred_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_dn     (up_dn),
    .stuck_en  (stuck_en),
    .stuck_val (stuck_val),
    .state_o   (state_o),
    .alarm_o   (alarm_o)
  );

  // R2 test set as given in the requirement
  task automatic lookup(input logic d, input logic [1:0] s,
                        output logic h, output logic [1:0] p);
    h = 1'b1;
    case ({d, s})
      3'b100:  p = 2'b01;
      3'b101:  p = 2'b10;
      3'b011:  p = 2'b10;
      3'b000:  p = 2'b11;
      default: begin h = 1'b0; p = 2'b00; end
    endcase
  endtask

  // driver: one transition, expected result pushed to the scoreboard
  task automatic step(input logic d, input logic [1:0] se, input logic [1:0] sv,
                      input string tag);
    logic [1:0] raw, ns, pn;
    logic       h;
    exp_t       e;
    @(negedge clk);
    rst_n = 1'b1; up_dn = d; stuck_en = se; stuck_val = sv;
    raw = d ? 2'(m_st + 2'd1) : 2'(m_st - 2'd1);
    ns  = (raw & ~se) | (sv & se);
    lookup(d, m_st, h, pn);
    m_al = m_al | (m_pv && (m_st != m_pp));
    m_pv = h; m_pp = pn; m_st = ns;
    e.st = ns; e.al = m_al; e.tag = tag;
    q.push_back(e);
  endtask

  // reset is left asserted; the next step releases it
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stuck_en = 2'b00; stuck_val = 2'b00;
    m_st = 2'b00; m_pp = 2'b00; m_pv = 1'b0; m_al = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (state_o !== 2'b00) begin
      failures++;
      $display("FAIL R6 reset state act=%b exp=00", state_o);
    end
    checks++;
    if (alarm_o !== 1'b0) begin
      failures++;
      $display("FAIL R6 reset alarm act=%b exp=0", alarm_o);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() != 0) begin
      e = q.pop_front();
      checks++;
      if (state_o !== e.st) begin
        failures++;
        $display("FAIL %s state act=%b exp=%b", e.tag, state_o, e.st);
      end
      checks++;
      if (alarm_o !== e.al) begin
        failures++;
        $display("FAIL %s alarm act=%b exp=%b", e.tag, alarm_o, e.al);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; up_dn = 1'b1; stuck_en = 2'b00; stuck_val = 2'b00;
    m_st = 2'b00; m_pp = 2'b00; m_pv = 1'b0; m_al = 1'b0;

    // R1 / R2: full loop both ways, fault-free
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 2'b00, 2'b00, "R1 up");
    for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 2'b00, "R2 down");
    step(1'b0, 2'b00, 2'b00, "R2 settle");

    // R3: fault on a non-test pair is masked
    do_reset();
    step(1'b1, 2'b00, 2'b00, "R3 to 01");
    step(1'b1, 2'b00, 2'b00, "R3 to 10");
    step(1'b1, 2'b00, 2'b00, "R3 to 11");
    step(1'b1, 2'b01, 2'b01, "R3 masked fault");
    step(1'b0, 2'b00, 2'b00, "R3 after mask");
    step(1'b0, 2'b00, 2'b00, "R3 down 00");
    step(1'b0, 2'b00, 2'b00, "R3 down 11");
    step(1'b0, 2'b00, 2'b00, "R3 down 10");

    // R8: each polarity on each bit
    do_reset();
    step(1'b1, 2'b01, 2'b00, "R8 bit0 low");
    step(1'b1, 2'b00, 2'b00, "R8 bit0 low detect");
    step(1'b1, 2'b00, 2'b00, "R5 bit0 low hold");

    do_reset();
    step(1'b1, 2'b10, 2'b10, "R8 bit1 high");
    step(1'b1, 2'b00, 2'b00, "R8 bit1 high detect");
    step(1'b1, 2'b00, 2'b00, "R5 bit1 high hold");

    do_reset();
    step(1'b1, 2'b00, 2'b00, "R8 prep");
    step(1'b1, 2'b01, 2'b01, "R8 bit0 high");
    step(1'b1, 2'b00, 2'b00, "R8 bit0 high detect");
    step(1'b1, 2'b00, 2'b00, "R5 bit0 high hold");

    do_reset();
    step(1'b1, 2'b00, 2'b00, "R8 prep");
    step(1'b1, 2'b10, 2'b00, "R8 bit1 low");
    step(1'b1, 2'b00, 2'b00, "R8 bit1 low detect");
    step(1'b1, 2'b00, 2'b00, "R5 bit1 low hold");

    // R4: down-direction fault, then R5 sticky over many cycles
    do_reset();
    step(1'b0, 2'b00, 2'b00, "R4 prep");
    step(1'b0, 2'b10, 2'b00, "R4 down fault");
    step(1'b0, 2'b00, 2'b00, "R4 detect");
    for (int i = 0; i < 6; i++) step(i[0], 2'b00, 2'b00, "R5 sticky");

    // R7: override equal to correct value
    do_reset();
    step(1'b1, 2'b01, 2'b01, "R7 harmless");
    step(1'b1, 2'b00, 2'b00, "R7 after");
    step(1'b1, 2'b00, 2'b00, "R7 after");

    // R5 / R6: reset clears the alarm
    do_reset();
    step(1'b1, 2'b00, 2'b00, "R6 post reset");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule